// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Sequencer

This block is the digital core of a display row scanner. A single start token is captured on a rising clock edge. It then steps along a chain of 263 stages, one stage per rising edge, and each gate output is high while its stage holds the token. The scan can run from the low-numbered end to the high-numbered end, or in the opposite direction. Whichever start pin is not used as the input becomes the cascade output, which starts the next scanner in a chain.

A mode input selects 263 or 256 active outputs. In the short mode, a fixed run of seven middle outputs is removed from the scan and held low. Three output-enable lines mask interleaved groups of outputs, and the position counted among the active outputs decides which line masks which output. An active-low all-on input overrides every enable and drives all active outputs high. Neither the enables nor all-on disturb the token in the chain.

The interface is plain control pins and carries no stream, so there is no valid/ready handshake. When the mode and all-on pins are left undriven, the integrator ties them high. This gives the full 263-output mode with all-on inactive.

Top module: `gate_scan_core`

## Requirements
- R1: A start level present at a rising edge puts the token into the first stage of the scan at that edge. The token then moves one active stage per rising edge and leaves the chain one edge after it reaches the final active stage. With all enables low and all-on high, at most one gate output is high in any cycle.
- R2: With `dir_right`=1 the token enters from `start_r_i` at gate_o[0] and moves toward gate_o[262]. With `dir_right`=0 it enters from `start_l_i` at gate_o[262] and moves toward gate_o[0].
- R3: The cascade pin on the far side (`casc_l_o` when `dir_right`=1, `casc_r_o` when `dir_right`=0) goes high at the falling edge that follows the rising edge which loads the final active stage. In full mode that is the 263rd clock after the start; in short mode it is the 256th. The pin goes low at the next falling edge. The cascade pin on the input side stays 0.
- R4: With `mode_full`=0, gate_o[128] through gate_o[134] read 0 at all times, including under all-on. In this mode the token passes directly between gate_o[127] and gate_o[135] in either direction.
- R5: Each active output is masked by oe_i[p mod 3], where p is its zero-based position among the active outputs counted from gate_o[0]. In full mode p equals the bit index. In short mode p is the bit index minus 7 for bits 135 and above, so gate_o[135] uses oe_i[2] and gate_o[136] uses oe_i[0].
- R6: While an enable bit is 1, the outputs of its group read 0 in the same cycle, without waiting for a clock edge. The token keeps moving and shows again once the enable returns to 0.
- R7: While `all_on_n`=0, every active output reads 1 whatever the enables are. The token keeps moving underneath.
- R8: `rst`=1, sampled at a clock edge, empties the chain and clears the cascade output. An output that is neither holding the token nor forced on reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_r_i | input | 1 | Start token input used when dir_right=1 |
| start_l_i | input | 1 | Start token input used when dir_right=0 |
| dir_right | input | 1 | 1: scan from gate_o[0] upward; 0: scan from gate_o[262] downward |
| mode_full | input | 1 | 1: 263 active outputs; 0: 256 active outputs |
| oe_i | input | 3 | Group mask enables, active high |
| all_on_n | input | 1 | Active-low override that drives all active outputs high |
| gate_o | output | 263 | Gate line outputs, bit 0 is the first line |
| casc_r_o | output | 1 | Cascade start out when dir_right=0 |
| casc_l_o | output | 1 | Cascade start out when dir_right=1 |

## Verification
On every cycle, the assertions check the following: the seven skipped lines stay dark in short mode, all-on lights every active line, the first two lines follow their enable groups, the input-side cascade pin stays silent, and the token steps between neighbouring lines in each direction. Other properties depend on a whole frame and only the bench's scenarios can show them. These are the full scan order in both directions and both modes, the jump across the skipped block, the rotation of the enable groups after that jump, the exact falling edge at which the cascade pulse rises and falls, and the token surviving masking, override and a mid-frame reset.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

  // Enable group of a physical stage; in the reduced mode the stages past
  // the removed block shift down by the block length before the rotation.
  function automatic int en_group(int idx, bit full, int skip_lo, int skip_n, int n_en);
    if (!full && idx >= skip_lo + skip_n)
      return (idx - skip_n) % n_en;
    return idx % n_en;
  endfunction

endpackage

// File: rtl/gsd_chain.sv
module gsd_chain #(
  parameter int N       = 263,
  parameter int SKIP_LO = 128,
  parameter int SKIP_N  = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         short_mode,
  input  logic         dir_right,
  input  logic         start_r_i,
  input  logic         start_l_i,
  output logic [N-1:0] tok
);
  localparam int SKIP_HI = SKIP_LO + SKIP_N - 1;

  logic [N-1:0] from_r;
  logic [N-1:0] from_l;
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_stage
    // source when scanning upward
    if (i == 0) begin : g_r_head
      assign from_r[i] = start_r_i;
    end else if (i == SKIP_HI + 1) begin : g_r_jump
      assign from_r[i] = short_mode ? tok[SKIP_LO-1] : tok[i-1];
    end else begin : g_r_plain
      assign from_r[i] = tok[i-1];
    end

    // source when scanning downward
    if (i == N - 1) begin : g_l_head
      assign from_l[i] = start_l_i;
    end else if (i == SKIP_LO - 1) begin : g_l_jump
      assign from_l[i] = short_mode ? tok[SKIP_HI+1] : tok[i+1];
    end else begin : g_l_plain
      assign from_l[i] = tok[i+1];
    end

    if (i >= SKIP_LO && i <= SKIP_HI) begin : g_skippable
      assign nxt[i] = !short_mode && (dir_right ? from_r[i] : from_l[i]);
    end else begin : g_always
      assign nxt[i] = dir_right ? from_r[i] : from_l[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tok <= '0;
    else     tok <= nxt;
  end
endmodule

// File: rtl/gsd_out_gate.sv
module gsd_out_gate #(
  parameter int N       = 263,
  parameter int SKIP_LO = 128,
  parameter int SKIP_N  = 7,
  parameter int N_EN    = 3
) (
  input  logic [N-1:0]    tok,
  input  logic            short_mode,
  input  logic [N_EN-1:0] oe_i,
  input  logic            all_on_n,
  output logic [N-1:0]    gate_o
);
  localparam int SKIP_HI = SKIP_LO + SKIP_N - 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int GF = gsd_pkg::en_group(i, 1'b1, SKIP_LO, SKIP_N, N_EN);
    localparam int GS = gsd_pkg::en_group(i, 1'b0, SKIP_LO, SKIP_N, N_EN);
    logic mask;
    logic active;
    assign mask   = short_mode ? oe_i[GS] : oe_i[GF];
    if (i >= SKIP_LO && i <= SKIP_HI) begin : g_sk
      assign active = !short_mode;
    end else begin : g_ns
      assign active = 1'b1;
    end
    assign gate_o[i] = active & (!all_on_n | (tok[i] & !mask));
  end
endmodule

// File: rtl/gsd_cascade.sv
module gsd_cascade (
  input  logic clk,
  input  logic rst,
  input  logic dir_right,
  input  logic last_up,
  input  logic last_down,
  output logic casc_r_o,
  output logic casc_l_o
);
  logic q;

  // launched on the falling edge, half a clock after the final stage loads
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= dir_right ? last_up : last_down;
  end

  assign casc_l_o = dir_right & q;
  assign casc_r_o = !dir_right & q;
endmodule

// File: rtl/gate_scan_core.sv
module gate_scan_core #(
  parameter int N       = 263,
  parameter int SKIP_LO = 128,
  parameter int SKIP_N  = 7,
  parameter int N_EN    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_r_i,
  input  logic            start_l_i,
  input  logic            dir_right,
  input  logic            mode_full,
  input  logic [N_EN-1:0] oe_i,
  input  logic            all_on_n,
  output logic [N-1:0]    gate_o,
  output logic            casc_r_o,
  output logic            casc_l_o
);
  logic [N-1:0] tok;
  logic         short_mode;

  assign short_mode = !mode_full;

  gsd_chain #(.N(N), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_chain (
    .clk(clk), .rst(rst), .short_mode(short_mode), .dir_right(dir_right),
    .start_r_i(start_r_i), .start_l_i(start_l_i), .tok(tok)
  );

  gsd_out_gate #(.N(N), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N), .N_EN(N_EN)) u_gate (
    .tok(tok), .short_mode(short_mode), .oe_i(oe_i), .all_on_n(all_on_n),
    .gate_o(gate_o)
  );

  gsd_cascade u_casc (
    .clk(clk), .rst(rst), .dir_right(dir_right),
    .last_up(tok[N-1]), .last_down(tok[0]),
    .casc_r_o(casc_r_o), .casc_l_o(casc_l_o)
  );
endmodule

// File: rtl/gsd_checker.sv
module gsd_checker #(
  parameter int N       = 263,
  parameter int SKIP_LO = 128,
  parameter int SKIP_N  = 7,
  parameter int N_EN    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            dir_right,
  input logic            mode_full,
  input logic [N_EN-1:0] oe_i,
  input logic            all_on_n,
  input logic [N-1:0]    gate_o,
  input logic            casc_r_o,
  input logic            casc_l_o
);
  // R4: removed block stays dark in short mode
  p_skip_dark_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_full |-> gate_o[SKIP_LO +: SKIP_N] == '0);

  // R7: override lights everything active
  p_all_on_low_r7: assert property (@(posedge clk) disable iff (rst)
    !all_on_n |-> &gate_o[SKIP_LO-1:0]);
  p_all_on_full_r7: assert property (@(posedge clk) disable iff (rst)
    (!all_on_n && mode_full) |-> &gate_o);

  // R6: first two lines belong to groups 0 and 1
  p_oe0_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (all_on_n && oe_i[0]) |-> !gate_o[0]);
  p_oe1_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (all_on_n && oe_i[1]) |-> !gate_o[1]);

  // R3: input-side cascade pin silent
  p_casc_side_up_r3: assert property (@(posedge clk) disable iff (rst)
    dir_right |-> !casc_r_o);
  p_casc_side_down_r3: assert property (@(posedge clk) disable iff (rst)
    !dir_right |-> !casc_l_o);

  // R2: neighbour stepping in each direction while unmasked
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (dir_right && all_on_n && oe_i == '0 &&
     $past(!rst && dir_right && all_on_n && oe_i == '0))
    |-> gate_o[5] == $past(gate_o[4]));
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!dir_right && all_on_n && oe_i == '0 &&
     $past(!rst && !dir_right && all_on_n && oe_i == '0))
    |-> gate_o[4] == $past(gate_o[5]));
endmodule

bind gate_scan_core gsd_checker #(.N(N), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N), .N_EN(N_EN)) u_chk (
  .clk(clk), .rst(rst), .dir_right(dir_right), .mode_full(mode_full),
  .oe_i(oe_i), .all_on_n(all_on_n), .gate_o(gate_o),
  .casc_r_o(casc_r_o), .casc_l_o(casc_l_o)
);

// File: tb/sim_gate_scan_core.sv
module sim_gate_scan_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_r_i = 1'b0;
  logic         start_l_i = 1'b0;
  logic         dir_right = 1'b1;
  logic         mode_full = 1'b1;
  logic [2:0]   oe_i = 3'b000;
  logic         all_on_n = 1'b1;
  logic [262:0] gate_o;
  logic         casc_r_o;
  logic         casc_l_o;

  int n_chk = 0;
  int n_err = 0;
  int pos   = -1;     // scan step holding the token, -1 when empty
  bit st_d  = 1'b0;
  bit rst_d = 1'b1;

  always #4 clk = ~clk;

  gate_scan_core u0 (
    .clk(clk), .rst(rst), .start_r_i(start_r_i), .start_l_i(start_l_i),
    .dir_right(dir_right), .mode_full(mode_full), .oe_i(oe_i),
    .all_on_n(all_on_n), .gate_o(gate_o), .casc_r_o(casc_r_o), .casc_l_o(casc_l_o)
  );

  function automatic int cnt_f(bit f);
    return f ? 263 : 256;
  endfunction

  function automatic int stage_of(int s, bit f, bit d);
    int r;
    r = (!f && s >= 128) ? s + 7 : s;
    return d ? r : 262 - r;
  endfunction

  function automatic logic [262:0] exp_gate(int s, bit f, bit d, logic [2:0] oe, bit aon_n);
    logic [262:0] v;
    int st;
    st = (s >= 0) ? stage_of(s, f, d) : -1;
    for (int i = 0; i < 263; i++) begin
      bit skipped;
      int p;
      skipped = !f && i >= 128 && i <= 134;
      p = (!f && i >= 135) ? i - 7 : i;
      if (skipped)     v[i] = 1'b0;
      else if (!aon_n) v[i] = 1'b1;
      else             v[i] = (st == i) && !oe[p % 3];
    end
    return v;
  endfunction

  task automatic check_vec(string req, logic [262:0] act, logic [262:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: gate_o act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit st, logic [2:0] oe_v, bit aon_v, bit rst_v, string tag);
    bit q;
    @(posedge clk);
    if (rst_d)         pos = -1;
    else if (st_d)     pos = 0;
    else if (pos >= 0) pos = (pos + 1 < cnt_f(mode_full)) ? pos + 1 : -1;
    #1;
    rst = rst_v;
    start_r_i = st && dir_right;
    start_l_i = st && !dir_right;
    oe_i = oe_v;
    all_on_n = aon_v;
    st_d = st;
    rst_d = rst_v;
    #1;
    check_vec(tag, gate_o, exp_gate(pos, mode_full, dir_right, oe_v, aon_v));
    if (aon_v && oe_v == 3'b000)
      check_int("R1 one-hot", $countones(gate_o), (pos >= 0) ? 1 : 0);
    #4;
    q = !rst_v && pos >= 0 && pos == cnt_f(mode_full) - 1;
    check_int("R3 far cascade", dir_right ? int'(casc_l_o) : int'(casc_r_o), int'(q));
    check_int("R3 near cascade", dir_right ? int'(casc_r_o) : int'(casc_l_o), 0);
  endtask

  // kind 0: clean, 1: random masks/override, 2: fixed oe
  task automatic frame(bit d, bit f, int kind, logic [2:0] fix_oe, string tag);
    dir_right = d;
    mode_full = f;
    for (int k = 0; k < cnt_f(f) + 3; k++) begin
      logic [2:0] o;
      bit a;
      o = 3'b000;
      a = 1'b1;
      if (kind == 1) begin
        if ($urandom % 4 == 0) o = 3'($urandom);
        a = ($urandom % 8) != 0;
      end else if (kind == 2) begin
        o = fix_oe;
      end
      step(k == 0, o, a, 1'b0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R8: reset state
    for (int k = 0; k < 3; k++) step(1'b0, 3'b000, 1'b1, 1'b1, "R8 reset");
    step(1'b0, 3'b000, 1'b1, 1'b0, "R8 idle");

    frame(1'b1, 1'b1, 0, 3'b000, "R1 R2 up full");
    frame(1'b0, 1'b1, 0, 3'b000, "R2 down full");
    frame(1'b1, 1'b0, 0, 3'b000, "R4 up short");
    frame(1'b0, 1'b0, 0, 3'b000, "R4 down short");
    frame(1'b1, 1'b0, 2, 3'b011, "R5 short group map");
    frame(1'b0, 1'b1, 2, 3'b110, "R5 full group map");
    frame(1'b1, 1'b1, 1, 3'b000, "R6 R7 random up full");
    frame(1'b0, 1'b0, 1, 3'b000, "R6 R7 random down short");

    // R7: override beats all enables, token survives
    dir_right = 1'b1; mode_full = 1'b0;
    step(1'b1, 3'b000, 1'b1, 1'b0, "R7 start");
    for (int k = 0; k < 10; k++) step(1'b0, 3'b111, 1'b0, 1'b0, "R7 override");
    for (int k = 0; k < 260; k++) step(1'b0, 3'b000, 1'b1, 1'b0, "R6 R7 token kept");

    // R8: reset mid-frame empties the chain
    dir_right = 1'b0; mode_full = 1'b1;
    step(1'b1, 3'b000, 1'b1, 1'b0, "R8 start");
    for (int k = 0; k < 40; k++) step(1'b0, 3'b000, 1'b1, 1'b0, "R8 run");
    step(1'b0, 3'b000, 1'b1, 1'b1, "R8 mid reset");
    for (int k = 0; k < 240; k++) step(1'b0, 3'b000, 1'b1, 1'b0, "R8 empty after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1600000;
    n_err++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule